// File: doc/BRIEF.md
# Prescaled Square-Wave Timer

This block is a 16-bit up-counting timer. It steps once every 4^P system clocks, where P is a 3-bit prescale select. The count runs from zero up to one less than a programmed reload value, then returns to zero. Each return to zero is a wrap event. Every wrap sets a sticky interrupt flag. When clock-output mode is selected, every wrap also inverts an output pin. The pin then carries a 50% duty-cycle square wave at sysclk / (2 × reload × 4^P).

Clock-output mode is selected by three mode inputs: capture select low, counter select low and output enable high. A down-count enable input is present, but the block never uses it: the counter always counts up. When clock-output mode is not selected, the counter still runs and still raises the interrupt flag, but the output pin keeps its level. A run input starts and freezes the whole timer.

Top module: `clkout_timer`

## Requirements
- R1: While rst_n is low, and right after it is released, count is 0, clk_out is 0 and irq_flag is 0.
- R2: clk_out can change only when cap_sel = 0, ctr_sel = 0 and out_en = 1. With any other combination of these three inputs, clk_out holds its level while the counter keeps running.
- R3: down_en has no effect: count, clk_out and irq_flag follow the same sequence whether it is 0 or 1.
- R4: With run_en high, the counter takes one step every 4^P clock cycles, where P is the unsigned value of pre_sel. The first step comes on the 4^P-th rising edge after reset.
- R5: For a non-zero reload R, count steps 0, 1, …, R−1 and then returns to 0; that return is the wrap. In clock-output mode, clk_out inverts on each wrap, so it stays R × 4^P cycles high and R × 4^P cycles low.
- R6: While run_en is low, count, the prescaler phase and clk_out all hold their values, and counting resumes from the held phase.
- R7: With reload_val = 0, count stays where it is, no wrap occurs, clk_out holds and irq_flag is not set.
- R8: irq_flag is set on every wrap and stays set until irq_clr is sampled high. If a wrap and irq_clr occur in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Timer runs while high |
| pre_sel | input | 3 | Prescale select P; step every 4^P cycles |
| reload_val | input | 16 | Reload value R; the count wraps after R−1 |
| cap_sel | input | 1 | Capture select; must be 0 for clock output |
| ctr_sel | input | 1 | Counter select; must be 0 for clock output |
| out_en | input | 1 | Output enable; must be 1 for clock output |
| down_en | input | 1 | Down-count enable; ignored |
| irq_clr | input | 1 | Clears irq_flag |
| clk_out | output | 1 | Square-wave output |
| count | output | 16 | Current count |
| irq_flag | output | 1 | Sticky wrap flag |

## Verification
The bench checks the edge on which the largest prescale makes its first step. A design with an off-by-one prescaler would toggle at 16383 or 16385 cycles instead of 16384. Reload values of 1 and 0 are exercised. A reload of 1 must toggle on every step. A reload of 0 must not wrap; a design that decremented the reload would run away with a 65536-count period. Each of the three mode inputs is put in its failing state in turn, and down_en is raised in one case. A gate missing a term would still produce a square wave, and a design that honoured down_en would show a different count. A stop in the middle of a prescale period shows whether a design clears the prescaler phase while stopped, because that makes the next step late.

// File: rtl/clkout_timer_pkg.sv
// Package: shared mode type and the clock-output mode decode.
// Assumes the mode inputs are sampled as static levels by the timer.
package clkout_timer_pkg;

    typedef struct packed {
        logic cap_sel;
        logic ctr_sel;
        logic out_en;
        logic down_en;
    } tmr_mode_t;

    // True when the three gating bits select square-wave output.
    function automatic logic clk_mode_on(tmr_mode_t m);
        return (!m.cap_sel) && (!m.ctr_sel) && m.out_en;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
// Prescaler: issues a one-cycle tick every 4^pre_sel clocks while run is high.
// Assumes the phase counter is wide enough for the largest ratio; the phase
// is held (not cleared) while run is low.
module tmr_prescale #(
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSEL_W-1:0] pre_sel,
    output logic              tick
);
    localparam int DIV_W = 2 * ((1 << PSEL_W) - 1);

    logic [DIV_W-1:0] phase;
    logic [DIV_W:0]   limit;

    // Terminal phase value for the selected ratio.
    always_comb begin
        limit = ({{DIV_W{1'b0}}, 1'b1} << {pre_sel, 1'b0}) - 1'b1;
        tick  = run && ({1'b0, phase} >= limit);
    end

    // Advance the phase while running; restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (tick)
            phase <= '0;
        else if (run)
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/tmr_count.sv
// Main counter: counts up on each tick from 0 to reload-1, then wraps to 0.
// Assumes a reload of 0 means "stopped": no step and no wrap.
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic live;

    // Wrap detection; >= also recovers if reload drops below the count.
    always_comb begin
        live = tick && (reload != '0);
        wrap = live && (count >= reload - 1'b1);
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (wrap)
            count <= '0;
        else if (live)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/tmr_wave.sv
// Output stage: toggles the square wave on wraps in clock-output mode and
// keeps the sticky interrupt flag. Assumes wrap is a single-cycle pulse.
module tmr_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic mode_on,
    input  logic irq_clr,
    output logic clk_out,
    output logic irq_flag
);
    // Square-wave flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_out <= 1'b0;
        else if (wrap && mode_on)
            clk_out <= ~clk_out;
    end

    // Sticky flag; a wrap wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_flag <= 1'b0;
        else if (wrap)
            irq_flag <= 1'b1;
        else if (irq_clr)
            irq_flag <= 1'b0;
    end
endmodule

// File: rtl/clkout_timer.sv
// Top: prescaled up-counting timer with a square-wave clock output.
// Assumes all control inputs are synchronous to clk; down_en is accepted
// but never used, since this timer only counts up.
module clkout_timer
    import clkout_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [PSEL_W-1:0] pre_sel,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              cap_sel,
    input  logic              ctr_sel,
    input  logic              out_en,
    input  logic              down_en,
    input  logic              irq_clr,
    output logic              clk_out,
    output logic [CNT_W-1:0]  count,
    output logic              irq_flag
);
    tmr_mode_t mode;
    logic      mode_on;
    logic      tick;
    logic      wrap;
    logic      unused_dn;

    // Gather the mode inputs and decode clock-output mode.
    always_comb begin
        mode      = '{cap_sel: cap_sel, ctr_sel: ctr_sel,
                      out_en: out_en, down_en: down_en};
        mode_on   = clk_mode_on(mode);
        unused_dn = mode.down_en;
    end

    tmr_prescale #(.PSEL_W(PSEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_en),
        .pre_sel(pre_sel), .tick(tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .reload(reload_val), .count(count), .wrap(wrap)
    );

    tmr_wave u_wave (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .mode_on(mode_on),
        .irq_clr(irq_clr), .clk_out(clk_out), .irq_flag(irq_flag)
    );
endmodule

// File: rtl/clkout_timer_chk.sv
// Checker: temporal properties of the timer, observed at its ports.
module clkout_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic [CNT_W-1:0] reload_val,
    input logic             cap_sel,
    input logic             ctr_sel,
    input logic             out_en,
    input logic             irq_clr,
    input logic             clk_out,
    input logic [CNT_W-1:0] count,
    input logic             irq_flag
);
    logic gate_ok;
    assign gate_ok = !cap_sel && !ctr_sel && out_en;

    // R2: no output change outside clock-output mode
    a_r2_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_ok |=> $stable(clk_out));

    // R6: stopped timer holds count and output
    a_r6_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(count));
    a_r6_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(clk_out));

    // R7: zero reload freezes the count
    a_r7_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_val == '0) |=> $stable(count));

    // R5: count moves only by one step or back to zero
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (count == '0 || count == $past(count) + 1'b1));

    // R8: output toggle implies the flag is set; flag drops only on a clear
    a_r8_flag_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_out) |-> irq_flag);
    a_r8_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(irq_clr));
endmodule

bind clkout_timer clkout_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .reload_val(reload_val),
    .cap_sel(cap_sel), .ctr_sel(ctr_sel), .out_en(out_en),
    .irq_clr(irq_clr), .clk_out(clk_out), .count(count),
    .irq_flag(irq_flag)
);

// File: tb/clkout_timer_test.sv
module clkout_timer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en;
    logic [2:0]  pre_sel;
    logic [15:0] reload_val;
    logic        cap_sel, ctr_sel, out_en, down_en, irq_clr;
    logic        clk_out;
    logic [15:0] count;
    logic        irq_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    clkout_timer uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_sel(pre_sel),
        .reload_val(reload_val), .cap_sel(cap_sel), .ctr_sel(ctr_sel),
        .out_en(out_en), .down_en(down_en), .irq_clr(irq_clr),
        .clk_out(clk_out), .count(count), .irq_flag(irq_flag)
    );

    typedef struct packed {
        logic [2:0]  p;
        logic [15:0] r;
        logic        cap, ctr, oe, dn;
        logic [31:0] n;
        logic [15:0] exp_cnt;
        logic [31:0] exp_tog;
        logic        exp_irq;
    } vec_t;

    // expected: ticks T = n / 4^p, count = T mod r, toggles = T / r if mode on
    localparam vec_t VECS [9] = '{
        '{3'd0, 16'd5, 1'b0, 1'b0, 1'b1, 1'b0, 32'd23, 16'd3, 32'd4, 1'b1}, // R5
        '{3'd1, 16'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'd50, 16'd0, 32'd4, 1'b1}, // R4
        '{3'd0, 16'd4, 1'b0, 1'b0, 1'b1, 1'b1, 32'd10, 16'd2, 32'd2, 1'b1}, // R3
        '{3'd0, 16'd4, 1'b0, 1'b0, 1'b0, 1'b0, 32'd10, 16'd2, 32'd0, 1'b1}, // R2
        '{3'd0, 16'd4, 1'b1, 1'b0, 1'b1, 1'b0, 32'd10, 16'd2, 32'd0, 1'b1}, // R2
        '{3'd0, 16'd4, 1'b0, 1'b1, 1'b1, 1'b0, 32'd10, 16'd2, 32'd0, 1'b1}, // R2
        '{3'd2, 16'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'd70, 16'd0, 32'd2, 1'b1}, // R4
        '{3'd0, 16'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'd20, 16'd0, 32'd0, 1'b0}, // R7
        '{3'd0, 16'd1, 1'b0, 1'b0, 1'b1, 1'b0, 32'd7,  16'd0, 32'd7, 1'b1}  // R5
    };

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0; irq_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup(input logic [2:0] p, input logic [15:0] r,
                         input logic cap, input logic ctr,
                         input logic oe, input logic dn);
        pre_sel = p; reload_val = r;
        cap_sel = cap; ctr_sel = ctr; out_en = oe; down_en = dn;
    endtask

    // Run for n rising edges, counting output toggles seen at negedges.
    task automatic run_for(input int n, output int toggles);
        logic prev;
        prev = clk_out;
        toggles = 0;
        run_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_out !== prev) toggles++;
            prev = clk_out;
        end
        run_en = 1'b0;
    endtask

    initial begin
        int tg;
        logic [15:0] held_cnt;
        logic        held_out;
        rst_n = 1'b0; run_en = 1'b0; irq_clr = 1'b0;
        setup(3'd0, 16'd5, 1'b0, 1'b0, 1'b1, 1'b0);

        // R1: reset state
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 clk_out", clk_out, 0);
        chk("R1 irq_flag", irq_flag, 0);

        // Vector table
        for (int v = 0; v < 9; v++) begin
            do_reset();
            setup(VECS[v].p, VECS[v].r, VECS[v].cap, VECS[v].ctr,
                  VECS[v].oe, VECS[v].dn);
            run_for(int'(VECS[v].n), tg);
            chk($sformatf("R2/R3/R4/R5/R7 vec%0d count", v), count, VECS[v].exp_cnt);
            chk($sformatf("R2/R3/R5/R7 vec%0d toggles", v), tg, VECS[v].exp_tog);
            chk($sformatf("R8/R7 vec%0d irq", v), irq_flag, VECS[v].exp_irq);
        end

        // R8: clear while stopped, then set-wins-over-clear
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R8 cleared", irq_flag, 0);
        do_reset();
        setup(3'd0, 16'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        irq_clr = 1'b1;
        run_for(1, tg);
        irq_clr = 1'b0;
        chk("R8 wrap beats clear", irq_flag, 1);

        // R5: 50% duty, reload 3 at P=0 -> after edge k, out = (k/3) mod 2
        do_reset();
        setup(3'd0, 16'd3, 1'b0, 1'b0, 1'b1, 1'b0);
        run_en = 1'b1;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            chk($sformatf("R5 duty edge %0d", k), clk_out, (k / 3) % 2);
            chk($sformatf("R5 count edge %0d", k), count, k % 3);
        end
        run_en = 1'b0;

        // R6: hold while stopped, prescaler phase kept (P=1)
        do_reset();
        setup(3'd1, 16'd100, 1'b0, 1'b0, 1'b1, 1'b0);
        run_for(6, tg);
        held_cnt = count;
        held_out = clk_out;
        repeat (5) @(negedge clk);
        chk("R6 count held", count, held_cnt);
        chk("R6 count value", count, 1);
        chk("R6 out held", clk_out, held_out);
        run_for(2, tg);
        chk("R6 phase resumed", count, 2);

        // R4: largest prescale, first step on edge 16384
        do_reset();
        setup(3'd7, 16'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        run_for(16383, tg);
        chk("R4 no step at 16383", clk_out, 0);
        chk("R4 no irq at 16383", irq_flag, 0);
        run_for(1, tg);
        chk("R4 step at 16384", clk_out, 1);
        chk("R4 irq at 16384", irq_flag, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule